// File: doc/BRIEF.md
# Debug Break Injection Unit

This unit sits beside a CPU core's instruction sequencer and turns a break request from an address comparator into a software-interrupt entry. A request that arrives partway through an instruction is held as pending until the instruction finishes. A request that arrives on an instruction's closing cycle is taken at that boundary, so no further instruction runs first. When the break is taken, the unit overrides the instruction register with the software-interrupt opcode for one cycle. It then presents the two vector byte addresses, high byte first, so the core can reload its program counter.

Two vector pairs exist: one for normal operation and one for monitor mode. The mode is captured on the cycle the break is taken. A break-active flag stays set from injection until the core completes a return-from-interrupt while the break request is low. While that flag is set, further requests have no effect.

Top module: `brk_inject`

## Requirements
- R1: After reset, `brk_pending`, `brk_active`, `ir_force` and `vec_valid` are all 0.
- R2: If `brk_req` is 1 on a cycle with `instr_last` 0 while nothing is active, `brk_pending` is 1 from the next cycle. It stays 1 even after `brk_req` drops, and no injection happens until a cycle with `instr_last` 1.
- R3: A take cycle is a cycle with `instr_last` 1, `brk_active` 0, and either `brk_pending` or `brk_req` at 1. `ir_force` is 1 exactly in the cycle after a take cycle. This includes a request that first appears on the take cycle itself.
- R4: While `ir_force` is 1, `ir_opcode` equals 8'h83.
- R5: In the cycle after `ir_force`, `vec_valid` is 1 with `vec_is_high` 1 and `vec_addr` equal to the pair base. In the cycle after that, `vec_valid` is 1 with `vec_is_high` 0 and `vec_addr` equal to base+1. Exactly these two vector cycles occur for each break.
- R6: The pair base is 16'hFFFC when `monitor_mode` was 0 on the take cycle and 16'hFEFC when it was 1. Later changes of `monitor_mode` do not alter the vector addresses of that break.
- R7: `brk_active` rises in the same cycle as `ir_force`. It falls in the cycle after a cycle in which `rti_done` is 1 and `brk_req` is 0.
- R8: `rti_done` on a cycle where `brk_req` is 1 leaves `brk_active` at 1.
- R9: While `brk_active` is 1, `brk_req` does not set `brk_pending` and causes no injection.
- R10: `brk_pending` is 0 in the `ir_force` cycle.
- R11: `rti_done` while `brk_active` is 0 changes neither flag and causes no injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_req | input | 1 | Break request level from the address comparator |
| instr_last | input | 1 | Current cycle is the last cycle of an instruction |
| monitor_mode | input | 1 | Monitor mode selects the alternate vector pair |
| rti_done | input | 1 | A return-from-interrupt completes this cycle |
| ir_force | output | 1 | Overrides the instruction register this cycle |
| ir_opcode | output | 8 | Opcode to load while `ir_force` is 1, zero otherwise |
| vec_valid | output | 1 | A vector byte address is presented |
| vec_is_high | output | 1 | The presented address is the high vector byte |
| vec_addr | output | 16 | Vector byte address, zero when not valid |
| brk_pending | output | 1 | A break waits for an instruction boundary |
| brk_active | output | 1 | A break is in service |

## Verification
The hardest case to reach is a deferred break whose request is already gone by the time the boundary arrives, with the mode changing right after it is taken. In that case the pending flag alone must carry the break, and the captured mode alone must pick the vector. The stimulus raises the request for one mid-instruction cycle with monitor mode set, then waits several non-boundary cycles. It then supplies the boundary and flips monitor mode low on the next cycle. The scoreboard expects the monitor vector pair at fixed cycle offsets from that boundary.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INJ  = 2'd1,
    ST_VHI  = 2'd2,
    ST_VLO  = 2'd3
  } brk_state_e;
endpackage

// File: rtl/brk_track.sv
module brk_track (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_req,
  input  logic instr_last,
  input  logic rti_done,
  output logic take,
  output logic pending,
  output logic active
);
  logic req_ok;
  logic rti_exit;

  assign req_ok   = pending | brk_req;
  assign take     = instr_last & ~active & req_ok;
  assign rti_exit = active & rti_done & ~brk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      active  <= 1'b0;
    end else if (take) begin
      pending <= 1'b0;
      active  <= 1'b1;
    end else begin
      if (!active && brk_req) pending <= 1'b1;
      if (rti_exit)           active  <= 1'b0;
    end
  end

  // R9
  active_blocks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> !pending);
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic ir_force,
  output logic vec_valid,
  output logic vec_hi
);
  brk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take) state_d = ST_INJ;
      ST_INJ:  state_d = ST_VHI;
      ST_VHI:  state_d = ST_VLO;
      ST_VLO:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ir_force  = (state_q == ST_INJ);
  assign vec_valid = (state_q == ST_VHI) || (state_q == ST_VLO);
  assign vec_hi    = (state_q == ST_VHI);

  // R5
  seq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_force, vec_valid}));
endmodule

// File: rtl/brk_vec_sel.sv
module brk_vec_sel #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC,
  parameter bit              LATCH_MON = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              monitor_mode,
  input  logic              vec_hi,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam logic [ADDR_W-1:0] LO_OFS = ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] pair_base(input logic mon);
    return mon ? VEC_MON : VEC_NORM;
  endfunction

  function automatic logic [ADDR_W-1:0] byte_addr(input logic [ADDR_W-1:0] base,
                                                  input logic hi);
    return hi ? base : base + LO_OFS;
  endfunction

  logic mon_sel;

  generate
    if (LATCH_MON) begin : g_latched
      logic mon_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mon_q <= 1'b0;
        else if (take) mon_q <= monitor_mode;
      end
      assign mon_sel = mon_q;
    end else begin : g_live
      assign mon_sel = monitor_mode;
    end
  endgenerate

  assign vec_addr = byte_addr(pair_base(mon_sel), vec_hi);
endmodule

// File: rtl/brk_inject.sv
module brk_inject #(
  parameter int                ADDR_W    = 16,
  parameter int                OPC_W     = 8,
  parameter logic [OPC_W-1:0]  SWI_OPC   = 8'h83,
  parameter logic [ADDR_W-1:0] VEC_NORM  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON   = 16'hFEFC,
  parameter bit                LATCH_MON = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req,
  input  logic              instr_last,
  input  logic              monitor_mode,
  input  logic              rti_done,
  output logic              ir_force,
  output logic [OPC_W-1:0]  ir_opcode,
  output logic              vec_valid,
  output logic              vec_is_high,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              brk_pending,
  output logic              brk_active
);
  logic              take;
  logic              vec_hi;
  logic [ADDR_W-1:0] addr_raw;

  brk_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_req    (brk_req),
    .instr_last (instr_last),
    .rti_done   (rti_done),
    .take       (take),
    .pending    (brk_pending),
    .active     (brk_active)
  );

  brk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .ir_force  (ir_force),
    .vec_valid (vec_valid),
    .vec_hi    (vec_hi)
  );

  brk_vec_sel #(
    .ADDR_W    (ADDR_W),
    .VEC_NORM  (VEC_NORM),
    .VEC_MON   (VEC_MON),
    .LATCH_MON (LATCH_MON)
  ) u_vec (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .monitor_mode (monitor_mode),
    .vec_hi       (vec_hi),
    .vec_addr     (addr_raw)
  );

  assign ir_opcode   = ir_force ? SWI_OPC : '0;
  assign vec_is_high = vec_valid & vec_hi;
  assign vec_addr    = vec_valid ? addr_raw : '0;

  // R3
  inject_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_force |-> $past(instr_last));

  // R10
  inject_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_force |-> (!brk_pending && brk_active));

  // R5
  hi_follows_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_force |=> (vec_valid && vec_is_high));

  // R5
  lo_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_is_high) |=>
      (vec_valid && !vec_is_high && vec_addr == $past(vec_addr) + ADDR_W'(1)));

  // R6
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_is_high) |-> (vec_addr == VEC_NORM || vec_addr == VEC_MON));

  // R7
  active_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) |-> ($past(rti_done) && !$past(brk_req)));
endmodule

// File: tb/brk_inject_tb.sv
module brk_inject_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        brk_req, instr_last, monitor_mode, rti_done;
  logic        ir_force, vec_valid, vec_is_high, brk_pending, brk_active;
  logic [7:0]  ir_opcode;
  logic [15:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int          at;
    int          kind;
    logic [15:0] val;
  } ev_t;
  ev_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brk_inject u_dut (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .instr_last(instr_last),
    .monitor_mode(monitor_mode), .rti_done(rti_done), .ir_force(ir_force),
    .ir_opcode(ir_opcode), .vec_valid(vec_valid), .vec_is_high(vec_is_high),
    .vec_addr(vec_addr), .brk_pending(brk_pending), .brk_active(brk_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver side: a break taken at the current cycle yields three events
  task automatic expect_break(input logic [15:0] base);
    sb.push_back('{at: cyc + 1, kind: 0, val: 16'h0083});
    sb.push_back('{at: cyc + 2, kind: 1, val: base});
    sb.push_back('{at: cyc + 3, kind: 2, val: base + 16'd1});
  endtask

  task automatic see(input int kind, input logic [15:0] val);
    ev_t e;
    if (sb.size() == 0) begin
      chk("R9 unexpected event", {kind[15:0], val}, 32'hFFFF_FFFF);
    end else begin
      e = sb.pop_front();
      chk("R3 event cycle", e.at, cyc);
      chk("R5 event kind", kind, e.kind);
      chk(kind == 0 ? "R4 opcode" : "R6 vector addr", val, e.val);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (ir_force)  see(0, {8'h00, ir_opcode});
      if (vec_valid) see(vec_is_high ? 1 : 2, vec_addr);
    end
  end

  initial begin
    rst_n = 1'b0; brk_req = 0; instr_last = 0; monitor_mode = 0; rti_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending", brk_pending, 0);
    chk("R1 active", brk_active, 0);
    chk("R1 ir_force", ir_force, 0);
    chk("R1 vec_valid", vec_valid, 0);

    // immediate break on a last cycle, normal mode
    brk_req = 1; instr_last = 1; monitor_mode = 0;
    expect_break(16'hFFFC);
    @(negedge clk);
    brk_req = 0; instr_last = 0;
    chk("R10 pending at inject", brk_pending, 0);
    chk("R7 active at inject", brk_active, 1);
    repeat (3) @(negedge clk);

    // requests while active are ignored
    brk_req = 1; instr_last = 1;
    @(negedge clk);
    chk("R9 pending while active", brk_pending, 0);
    @(negedge clk);
    chk("R9 pending while active", brk_pending, 0);
    brk_req = 0; instr_last = 0;
    repeat (3) @(negedge clk);

    // return with request still high keeps break active
    brk_req = 1; rti_done = 1;
    @(negedge clk);
    rti_done = 0; brk_req = 0;
    chk("R8 active kept", brk_active, 1);

    // qualifying return ends break
    rti_done = 1;
    @(negedge clk);
    rti_done = 0;
    chk("R7 active cleared", brk_active, 0);

    // return with no break in service
    rti_done = 1;
    @(negedge clk);
    rti_done = 0;
    chk("R11 active", brk_active, 0);
    chk("R11 pending", brk_pending, 0);
    @(negedge clk);
    chk("R11 ir_force", ir_force, 0);

    // deferred break, monitor mode captured at the boundary
    brk_req = 1; monitor_mode = 1;
    @(negedge clk);
    brk_req = 0;
    chk("R2 pending set", brk_pending, 1);
    chk("R2 no inject mid-instruction", ir_force, 0);
    repeat (2) @(negedge clk);
    chk("R2 pending held", brk_pending, 1);
    chk("R2 still no inject", ir_force, 0);
    instr_last = 1;
    expect_break(16'hFEFC);
    @(negedge clk);
    instr_last = 0; monitor_mode = 0;
    chk("R10 pending at inject", brk_pending, 0);
    chk("R7 active at inject", brk_active, 1);
    repeat (4) @(negedge clk);
    rti_done = 1;
    @(negedge clk);
    rti_done = 0;
    chk("R7 active cleared", brk_active, 0);

    repeat (3) @(negedge clk);
    chk("R5 all events seen", sb.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule